// File: doc/BRIEF.md
# Write Data Lane Steering Unit

This unit sits between the internal write path and the external data pins. It takes one write request: a 32-bit operand, a transfer size, the two low address bits and the width of the external port (32 or 16 bits). It works out which external byte lanes must carry which operand bytes, and which lanes must stay released. The result is a registered beat. The beat is held steady until the bus cycle engine acknowledges it. Byte and halfword writes are copied onto fixed extra lanes, so that a narrow device on either half of the bus sees its data.

When a word write targets a 16-bit port, the unit issues two halfword beats. The first beat carries the upper halfword at low address 0. The second carries the lower halfword at low address 2. An atomic indication covers both beats so that the bus is not given up between them. A request whose size is reserved, or whose address is not aligned to its size, is refused. The unit reports this with a one-cycle error pulse and drives no lanes.

Top module: `wr_lane_steer`

## Requirements
- R1: After reset, `req_ready` is 1, and `beat_valid`, `lane_oe`, `lane_data`, `atomic` and `req_err` are all 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. The resulting beat, or the error pulse, appears in the next cycle. `req_ready` is 0 while a beat is outstanding, and requests offered in that time have no effect. The port width (`narrow_port`: 1 means 16-bit, 0 means 32-bit) is captured when the request is taken.
- R3: While `beat_valid` is 1 and `beat_ack` is 0, the outputs `lane_data`, `lane_oe`, `beat_addr` and `atomic` hold their values into the next cycle. `beat_ack` has no effect while no beat is outstanding.
- R4: Size codes are 01 for a byte, 10 for a halfword, 00 for a word and 11 reserved. Lane 0 is `lane_data[31:24]` with enable `lane_oe[3]`, and lane 3 is `lane_data[7:0]` with enable `lane_oe[0]`. Operand byte k is `req_data[31-8k -: 8]`. On a 32-bit port, a byte at offset a always drives lane 0. Offset 1 also drives lane 1. Offset 2 also drives lane 2. Offset 3 also drives lanes 1 and 3. Every driven lane carries operand byte a.
- R5: On a 32-bit port, a halfword at offset 0 drives operand bytes 0 and 1 on lanes 0 and 1. A halfword at offset 2 drives bytes 2 and 3 on lanes 0 and 1, and again on lanes 2 and 3.
- R6: On a 32-bit port, a word at offset 0 drives operand bytes 0 to 3 on lanes 0 to 3 in one beat.
- R7: On a 16-bit port, a byte at an even offset drives lane 0, and a byte at an odd offset drives lane 1. A halfword at offset a drives operand bytes a and a+1 on lanes 0 and 1.
- R8: On a 16-bit port, a word at offset 0 becomes two beats. The first drives bytes 0 and 1 on lanes 0 and 1 with `beat_addr` 0. After it is acknowledged, the second beat follows in the next cycle and drives bytes 2 and 3 on lanes 0 and 1 with `beat_addr` 2. `atomic` is 1 from the first beat until the cycle after the second beat is acknowledged.
- R9: Size 11, a halfword at an odd offset, or a word at a nonzero offset gives `req_err` = 1 for exactly one cycle. No beat is issued and no lane is driven.
- R10: Any lane whose enable bit is 0 carries zero data. With no beat outstanding, all enables are 0. `beat_addr` equals the request offset, except on the second beat of a split.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| narrow_port | input | 1 | 1 selects a 16-bit external port, 0 selects a 32-bit port |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Unit can take a request |
| req_size | input | 2 | Transfer size code |
| req_addr | input | 2 | Low two address bits of the request |
| req_data | input | 32 | Write operand, byte 0 most significant |
| beat_valid | output | 1 | External beat presented to the bus cycle engine |
| beat_ack | input | 1 | Bus cycle engine completed the beat |
| beat_addr | output | 2 | Low address bits for the current beat |
| lane_data | output | 32 | Data on the external lanes |
| lane_oe | output | 4 | Per-lane drive enable, bit 3 for lane 0 |
| atomic | output | 1 | Split sequence in progress; bus must not be released |
| req_err | output | 1 | One-cycle pulse for a refused request |

## Verification
A wrong source or enable choice in the lane map shows up on `lane_data` or `lane_oe` in the very first cycle of the beat. The checks compare the lane map against a separately written table for every size, offset and port-width combination. A sequencer that loses the split phase shows up on the cycle after the first acknowledge in one of two ways: a second beat that never comes, or one with the wrong address or data. A sequencer that drops `atomic` too early shows up in that same cycle. Stale register contents after an acknowledge would show as enables or data that are still active while no beat is outstanding, one cycle after the final acknowledge.

// File: rtl/wr_lane_steer_pkg.sv
package wr_lane_steer_pkg;

   typedef enum logic [1:0] {
      SZ_WORD = 2'b00,
      SZ_BYTE = 2'b01,
      SZ_HALF = 2'b10,
      SZ_RSVD = 2'b11
   } xfer_size_e;

   // a request is refused when its size is reserved or its offset is not aligned to its size
   function automatic logic req_refused(input logic [1:0] size, input logic [1:0] ofs);
      logic bad;
      unique case (size)
         SZ_BYTE: bad = 1'b0;
         SZ_HALF: bad = ofs[0];
         SZ_WORD: bad = (ofs != 2'b00);
         default: bad = 1'b1;
      endcase
      return bad;
   endfunction

endpackage

// File: rtl/wr_lane_map.sv
module wr_lane_map
   import wr_lane_steer_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int ADDR_W = 2
) (
   input  logic              narrow,
   input  logic [1:0]        size,
   input  logic [ADDR_W-1:0] ofs,
   output logic [ADDR_W-1:0] sel [LANES],
   output logic [LANES-1:0]  en
);

   always_comb begin
      en = '0;
      for (int l = 0; l < LANES; l++) sel[l] = ADDR_W'(l);
      if (!narrow) begin
         unique case (size)
            SZ_BYTE: begin
               en[0]  = 1'b1;
               sel[0] = ofs;
               unique case (ofs)
                  2'd1: begin
                     en[1]  = 1'b1;
                     sel[1] = ofs;
                  end
                  2'd2: begin
                     en[2]  = 1'b1;
                     sel[2] = ofs;
                  end
                  2'd3: begin
                     en[1]  = 1'b1;
                     en[3]  = 1'b1;
                     sel[1] = ofs;
                     sel[3] = ofs;
                  end
                  default: ;
               endcase
            end
            SZ_HALF: begin
               en[0]  = 1'b1;
               en[1]  = 1'b1;
               sel[0] = {ofs[1], 1'b0};
               sel[1] = {ofs[1], 1'b1};
               if (ofs[1]) begin
                  en[2] = 1'b1;
                  en[3] = 1'b1;
               end
            end
            SZ_WORD: en = '1;
            default: ;
         endcase
      end else begin
         unique case (size)
            SZ_BYTE: begin
               if (ofs[0]) begin
                  en[1]  = 1'b1;
                  sel[1] = ofs;
               end else begin
                  en[0]  = 1'b1;
                  sel[0] = ofs;
               end
            end
            SZ_HALF, SZ_WORD: begin
               en[0]  = 1'b1;
               en[1]  = 1'b1;
               sel[0] = {ofs[1], 1'b0};
               sel[1] = {ofs[1], 1'b1};
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/wr_beat_seq.sv
module wr_beat_seq
   import wr_lane_steer_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              narrow_in,
   input  logic [1:0]        size_in,
   input  logic [ADDR_W-1:0] ofs_in,
   input  logic [DATA_W-1:0] data_in,
   input  logic              ack,
   output logic              busy,
   output logic              split,
   output logic              err,
   output logic              narrow_q,
   output logic [1:0]        size_q,
   output logic [ADDR_W-1:0] ofs_q,
   output logic [DATA_W-1:0] data_q
);

   localparam logic [ADDR_W-1:0] SECOND_OFS = ADDR_W'(2);

   logic second_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         split    <= 1'b0;
         second_q <= 1'b0;
         err      <= 1'b0;
         narrow_q <= 1'b0;
         size_q   <= SZ_BYTE;
         ofs_q    <= '0;
         data_q   <= '0;
      end else begin
         err <= 1'b0;
         if (busy) begin
            if (ack) begin
               if (split && !second_q) begin
                  second_q <= 1'b1;
                  size_q   <= SZ_HALF;
                  ofs_q    <= SECOND_OFS;
               end else begin
                  busy     <= 1'b0;
                  split    <= 1'b0;
                  second_q <= 1'b0;
               end
            end
         end else if (take) begin
            if (req_refused(size_in, ofs_in)) begin
               err <= 1'b1;
            end else begin
               busy     <= 1'b1;
               split    <= narrow_in && (size_in == SZ_WORD);
               second_q <= 1'b0;
               narrow_q <= narrow_in;
               size_q   <= size_in;
               ofs_q    <= ofs_in;
               data_q   <= data_in;
            end
         end
      end
   end

endmodule

// File: rtl/wr_lane_steer.sv
module wr_lane_steer
   import wr_lane_steer_pkg::*;
#(
   parameter int LANE_W = 8,
   parameter int LANES  = 4,
   parameter int ADDR_W = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      narrow_port,
   input  logic                      req_valid,
   output logic                      req_ready,
   input  logic [1:0]                req_size,
   input  logic [ADDR_W-1:0]         req_addr,
   input  logic [LANE_W*LANES-1:0]   req_data,
   output logic                      beat_valid,
   input  logic                      beat_ack,
   output logic [ADDR_W-1:0]         beat_addr,
   output logic [LANE_W*LANES-1:0]   lane_data,
   output logic [LANES-1:0]          lane_oe,
   output logic                      atomic,
   output logic                      req_err
);

   localparam int DATA_W = LANE_W * LANES;

   if (LANES != 4) begin : g_bad_lanes
      $error("wr_lane_steer: lane map is defined for four lanes only");
   end
   if (ADDR_W != $clog2(LANES)) begin : g_bad_addr
      $error("wr_lane_steer: ADDR_W must address one lane");
   end
   if (LANE_W < 1) begin : g_bad_lane_w
      $error("wr_lane_steer: LANE_W must be positive");
   end

   logic                busy, split, narrow_q;
   logic [1:0]          size_q;
   logic [ADDR_W-1:0]   ofs_q;
   logic [DATA_W-1:0]   data_q;
   logic [ADDR_W-1:0]   sel [LANES];
   logic [LANES-1:0]    en;

   assign req_ready = !busy;

   wr_beat_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (req_valid && req_ready),
      .narrow_in (narrow_port),
      .size_in   (req_size),
      .ofs_in    (req_addr),
      .data_in   (req_data),
      .ack       (beat_ack),
      .busy      (busy),
      .split     (split),
      .err       (req_err),
      .narrow_q  (narrow_q),
      .size_q    (size_q),
      .ofs_q     (ofs_q),
      .data_q    (data_q)
   );

   wr_lane_map #(.LANES(LANES), .ADDR_W(ADDR_W)) u_map (
      .narrow (narrow_q),
      .size   (size_q),
      .ofs    (ofs_q),
      .sel    (sel),
      .en     (en)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic drive;
      assign drive = busy && en[l];
      assign lane_oe[LANES-1-l] = drive;
      assign lane_data[DATA_W-1-l*LANE_W -: LANE_W] =
         drive ? data_q[DATA_W-1-int'(sel[l])*LANE_W -: LANE_W] : '0;
   end

   assign beat_valid = busy;
   assign beat_addr  = ofs_q;
   assign atomic     = busy && split;

endmodule

// File: rtl/wr_lane_steer_chk.sv
module wr_lane_steer_chk #(
   parameter int LANE_W = 8,
   parameter int LANES  = 4,
   parameter int ADDR_W = 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    req_valid,
   input logic                    req_ready,
   input logic                    beat_valid,
   input logic                    beat_ack,
   input logic [ADDR_W-1:0]       beat_addr,
   input logic [LANE_W*LANES-1:0] lane_data,
   input logic [LANES-1:0]        lane_oe,
   input logic                    atomic,
   input logic                    req_err
);

   localparam int DATA_W = LANE_W * LANES;

   p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> beat_valid || req_err);

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid && !beat_ack |=> beat_valid && $stable(lane_data) && $stable(lane_oe)
                                  && $stable(beat_addr) && $stable(atomic));

   p_split_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid && atomic && beat_addr == ADDR_W'(0) && beat_ack
      |=> beat_valid && atomic && beat_addr == ADDR_W'(2) && lane_oe == 4'b1100);

   p_split_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid && atomic && beat_addr == ADDR_W'(2) && beat_ack |=> !atomic && !beat_valid);

   p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_err |-> !beat_valid && lane_oe == '0);

   for (genvar l = 0; l < LANES; l++) begin : g_chk
      p_undriven_r10: assert property (@(posedge clk) disable iff (!rst_n)
         !lane_oe[LANES-1-l] |-> lane_data[DATA_W-1-l*LANE_W -: LANE_W] == '0);
   end

endmodule

bind wr_lane_steer wr_lane_steer_chk #(.LANE_W(LANE_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .beat_valid (beat_valid),
   .beat_ack   (beat_ack),
   .beat_addr  (beat_addr),
   .lane_data  (lane_data),
   .lane_oe    (lane_oe),
   .atomic     (atomic),
   .req_err    (req_err)
);

// File: tb/wr_lane_steer_test.sv
`timescale 1ns/1ps
module wr_lane_steer_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        narrow_port = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_size = 2'b01;
   logic [1:0]  req_addr = 2'b00;
   logic [31:0] req_data = '0;
   logic        beat_valid;
   logic        beat_ack = 1'b0;
   logic [1:0]  beat_addr;
   logic [31:0] lane_data;
   logic [3:0]  lane_oe;
   logic        atomic;
   logic        req_err;

   always #4 clk = ~clk;

   wr_lane_steer uut (
      .clk(clk), .rst_n(rst_n), .narrow_port(narrow_port),
      .req_valid(req_valid), .req_ready(req_ready), .req_size(req_size),
      .req_addr(req_addr), .req_data(req_data), .beat_valid(beat_valid),
      .beat_ack(beat_ack), .beat_addr(beat_addr), .lane_data(lane_data),
      .lane_oe(lane_oe), .atomic(atomic), .req_err(req_err)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   bit running = 1'b0;

   // behavioural model state
   bit         m_valid, m_split, m_second, m_err, m_narrow, m_hold;
   int         m_size, m_addr;
   logic [7:0] m_op [4];
   string      m_tag = "R10";

   function automatic void model_lanes(output logic [31:0] d, output logic [3:0] oe);
      logic [7:0] ln [4];
      bit en [4];
      for (int k = 0; k < 4; k++) begin ln[k] = 8'h00; en[k] = 0; end
      if (m_valid) begin
         if (!m_narrow) begin
            if (m_size == 1) begin
               en[0] = 1; ln[0] = m_op[m_addr];
               if (m_addr == 1) begin en[1] = 1; ln[1] = m_op[1]; end
               if (m_addr == 2) begin en[2] = 1; ln[2] = m_op[2]; end
               if (m_addr == 3) begin en[1] = 1; ln[1] = m_op[3]; en[3] = 1; ln[3] = m_op[3]; end
            end else if (m_size == 2) begin
               en[0] = 1; ln[0] = m_op[m_addr];
               en[1] = 1; ln[1] = m_op[m_addr + 1];
               if (m_addr == 2) begin
                  en[2] = 1; ln[2] = m_op[2];
                  en[3] = 1; ln[3] = m_op[3];
               end
            end else begin
               for (int k = 0; k < 4; k++) begin en[k] = 1; ln[k] = m_op[k]; end
            end
         end else begin
            if (m_second) begin
               en[0] = 1; ln[0] = m_op[2]; en[1] = 1; ln[1] = m_op[3];
            end else if (m_size == 1) begin
               if (m_addr % 2 == 1) begin en[1] = 1; ln[1] = m_op[m_addr]; end
               else begin en[0] = 1; ln[0] = m_op[m_addr]; end
            end else begin
               en[0] = 1; ln[0] = m_op[m_addr]; en[1] = 1; ln[1] = m_op[m_addr + 1];
            end
         end
      end
      d = {ln[0], ln[1], ln[2], ln[3]};
      oe = {en[0], en[1], en[2], en[3]};
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_valid = 0; m_split = 0; m_second = 0; m_err = 0; m_hold = 0;
      end else begin
         m_err  = 0;
         m_hold = m_valid && !beat_ack;
         if (m_valid) begin
            if (beat_ack) begin
               if (m_split && !m_second) m_second = 1;
               else begin m_valid = 0; m_split = 0; m_second = 0; end
            end
         end else if (req_valid) begin
            int s, a;
            s = int'(req_size); a = int'(req_addr);
            if (s == 3 || (s == 2 && a % 2 == 1) || (s == 0 && a != 0)) begin
               m_err = 1;
            end else begin
               m_valid = 1; m_second = 0; m_narrow = narrow_port;
               m_size = s; m_addr = a;
               m_split = narrow_port && s == 0;
               for (int k = 0; k < 4; k++) m_op[k] = req_data[31 - 8*k -: 8];
               if (narrow_port) m_tag = (s == 0) ? "R8" : "R7";
               else m_tag = (s == 1) ? "R4" : ((s == 2) ? "R5" : "R6");
            end
         end
      end
   end

   always @(negedge clk) begin
      if (running) begin
         logic [31:0] ed;
         logic [3:0]  eo;
         logic [1:0]  ea;
         string tag;
         model_lanes(ed, eo);
         ea = m_second ? 2'd2 : 2'(m_addr);
         if (!m_valid) ea = beat_addr;
         tag = m_err ? "R9" : (m_hold ? "R3" : (m_valid ? m_tag : "R10"));
         checks++;
         if (req_ready !== !m_valid) begin
            fails++;
            $display("FAIL R2: req_ready=%b expected %b", req_ready, !m_valid);
         end else if (beat_valid !== m_valid || req_err !== m_err || atomic !== (m_valid && m_split)) begin
            fails++;
            $display("FAIL %s: valid/err/atomic=%b%b%b expected %b%b%b", tag,
                     beat_valid, req_err, atomic, m_valid, m_err, m_valid && m_split);
         end else if (lane_oe !== eo || lane_data !== ed || beat_addr !== ea) begin
            fails++;
            $display("FAIL %s: oe=%b data=%h addr=%0d expected oe=%b data=%h addr=%0d", tag,
                     lane_oe, lane_data, beat_addr, eo, ed, ea);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      checks++;
      if (req_ready !== 1'b1 || beat_valid !== 1'b0 || lane_oe !== 4'b0 || lane_data !== '0
          || atomic !== 1'b0 || req_err !== 1'b0) begin
         fails++;
         $display("FAIL R1: ready=%b valid=%b oe=%b data=%h atomic=%b err=%b expected 1 0 0000 0 0 0",
                  req_ready, beat_valid, lane_oe, lane_data, atomic, req_err);
      end
      running = 1'b1;
      // every port width, size and offset, with irregular acknowledges
      for (int n = 0; n < 2; n++) begin
         for (int s = 0; s < 4; s++) begin
            for (int a = 0; a < 4; a++) begin
               while (!req_ready) begin
                  req_valid = 1'b0;
                  beat_ack  = ($urandom % 3) != 0;
                  @(negedge clk);
               end
               narrow_port = n[0];
               req_size    = 2'(s);
               req_addr    = 2'(a);
               req_data    = $urandom;
               req_valid   = 1'b1;
               beat_ack    = 1'b0;
               @(negedge clk);
               req_valid   = 1'b0;
               narrow_port = ~narrow_port;
               repeat (6) begin
                  beat_ack = ($urandom % 2) != 0;
                  @(negedge clk);
               end
            end
         end
      end
      // free-running stimulus: requests while busy, stray acks, port width changing
      for (int i = 0; i < 4000; i++) begin
         req_valid   = ($urandom % 2) != 0;
         narrow_port = ($urandom % 2) != 0;
         req_size    = 2'($urandom);
         req_addr    = 2'($urandom);
         req_data    = $urandom;
         beat_ack    = ($urandom % 4) != 0;
         @(negedge clk);
      end
      req_valid = 1'b0;
      beat_ack  = 1'b1;
      repeat (4) @(negedge clk);
      running = 1'b0;
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule